// File: doc/BRIEF.md
# Three-Wire Real-Time-Clock Register Slave

This block is the device end of a three-wire serial link (chip enable, serial clock, bidirectional data) used to reach the register file of a real-time clock. All three link inputs are oversampled in the system clock domain. Each bit is taken on a falling serial-clock edge, and bytes arrive most significant bit first. Every byte is decoded as a command. The register file has sixteen 4-bit locations. Time digits are stored one BCD nibble per location, with units and tens at separate addresses. The file also holds an interrupt-interval nibble, a control nibble and a test nibble. The data line is driven only while a read response is being shifted out; the port pair `sdo`/`sdo_oe` feeds an external tri-state pad.

A local port beside the serial link lets the timekeeping logic (or a test) preset any register and raise the oscillator-stopped flag. The timekeeping counter and the oscillator are outside this block. The address map is: 0x0/0x1 seconds units and tens, 0x2/0x3 minutes, 0x4/0x5 hours, 0x6 weekday, 0x7 interrupt interval, 0x8/0x9 day of month, 0xA/0xB month, 0xC/0xD year, 0xE control, 0xF test.

The link controller has four states. `S_IDLE` means chip enable is low. `S_CMD` means a byte is being assembled with no address pending. `S_ADDR_HELD` means a write address is pending. `S_READOUT` means the response byte is being driven. The transitions are:
- chip enable rising: `S_IDLE` to `S_CMD`.
- read byte complete: `S_CMD` or `S_ADDR_HELD` to `S_READOUT`.
- address byte complete: `S_CMD` or `S_ADDR_HELD` to `S_ADDR_HELD`.
- data or unrecognised byte complete: `S_ADDR_HELD` to `S_CMD`, and `S_CMD` stays in `S_CMD`.
- eighth response bit shifted: `S_READOUT` to `S_CMD`.
- chip enable falling: any state to `S_IDLE`.

Top module: `rtc3w_slave`

## Requirements
- R1: After reset the data line is released (`sdo_oe`=0, `sdo`=0). Every register reads 0, except control, which reads 0x2 because the stopped flag is set.
- R2: A byte with bit6=1 and bit5=1 (bit7 and bit4 ignored) reads the register at bits[3:0]. Over the next 8 falling serial-clock edges the slave drives, MSB first, four zero bits and then the nibble. `sdo_oe` is high for exactly those 8 bits and low afterwards.
- R3: A byte with bit5=1 and bit6=0 holds address bits[3:0]. The next byte, if it has bit4=1 and bit5=0, writes its bits[3:0] there. Several commands may follow one another within one chip-enable period.
- R4: A byte that arrives while an address is pending and is neither a data byte (bit4=1, bit5=0) nor a read or address byte writes nothing and drops the pending address. A data byte with no pending address writes nothing.
- R5: Chip enable low returns the bit counter to zero, drops any pending address and releases the data line within a few clocks.
- R6: The control nibble has the layout bit0 busy, bit1 oscillator stopped, bit2 12/24-hour select, bit3 spare flag. Bits 3:2 are writable. Bit1 ignores serial writes.
- R7: A serial write of control with bit0=1 makes bit0 read 1 for BUSY_CYCLES clocks, after which it clears by itself.
- R8: The stopped flag is set by reset and by a `loc_stop` pulse. It stays set until a serial write to a time-digit address (0x0–0x6, 0x8–0xD). Writes to 0x7, 0xE and 0xF leave it unchanged.
- R9: The test register stores only bit0. Bits 3:1 read 0.
- R10: A `loc_wr` pulse writes `loc_data` to `loc_addr`. For control it updates only bits 3:2. It never changes the stopped flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Link chip enable, active high |
| sclk | input | 1 | Link serial clock, idles high |
| sdi | input | 1 | Data line as seen at the pad input |
| sdo | output | 1 | Data line value to drive |
| sdo_oe | output | 1 | Data line output enable |
| loc_wr | input | 1 | Local register write strobe |
| loc_addr | input | 4 | Local write address |
| loc_data | input | 4 | Local write nibble |
| loc_stop | input | 1 | Sets the oscillator-stopped flag |

## Verification
The bench builds the slave with SYNC_STAGES=2 and BUSY_CYCLES=300. At that busy length, a control read issued straight after an adjust write still sees busy set. A read issued a few hundred clocks later sees it cleared by itself, so both sides of the busy window fall inside a short run. Half serial-clock phases of eight system clocks leave room for the synchroniser delay. They also allow chip enable to be dropped part-way through a command byte and part-way through a response.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

    localparam int NIB_W  = 4;
    localparam int ADR_W  = 4;
    localparam int NREG   = 1 << ADR_W;

    // command byte tag bits
    localparam int TAG_RD = 6;
    localparam int TAG_AD = 5;
    localparam int TAG_DT = 4;

    localparam logic [ADR_W-1:0] A_IVL  = 4'h7;
    localparam logic [ADR_W-1:0] A_CTRL = 4'hE;
    localparam logic [ADR_W-1:0] A_TEST = 4'hF;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CMD,
        S_ADDR_HELD,
        S_READOUT
    } link_st_e;

    function automatic logic is_time_addr(input logic [ADR_W-1:0] a);
        return (a != A_IVL) && (a < A_CTRL);
    endfunction

endpackage

// File: rtl/rtc3w_sync.sv
module rtc3w_sync #(
    parameter int           STAGES  = 2,
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[k] <= RST_VAL;
                else        pipe[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[k] <= RST_VAL;
                else        pipe[k] <= pipe[k-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/rtc3w_link.sv
module rtc3w_link
    import rtc3w_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_s,
    input  logic             sclk_s,
    input  logic             bit_s,
    input  logic [NIB_W-1:0] rd_nib,
    output logic [ADR_W-1:0] rd_addr,
    output logic             wr_stb,
    output logic [ADR_W-1:0] wr_addr,
    output logic [NIB_W-1:0] wr_nib,
    output logic             sdo,
    output logic             sdo_oe
);

    link_st_e st, st_nx;

    logic       sclk_q;
    logic [2:0] bcnt;
    logic [6:0] sh;
    logic [7:0] osh;
    logic [ADR_W-1:0] pend;

    logic       fall;
    logic       byte_end;
    logic [7:0] byte_w;
    logic       is_rd, is_ad, is_dt;

    assign fall     = sclk_q & ~sclk_s;
    assign byte_w   = {sh, bit_s};
    assign byte_end = fall && (bcnt == 3'd7);
    assign is_rd    = byte_w[TAG_RD] & byte_w[TAG_AD];
    assign is_ad    = byte_w[TAG_AD] & ~byte_w[TAG_RD];
    assign is_dt    = byte_w[TAG_DT] & ~byte_w[TAG_AD];

    // next-state decision
    always_comb begin
        st_nx = st;
        if (!ce_s) begin
            st_nx = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:      st_nx = S_CMD;
                S_CMD,
                S_ADDR_HELD: if (byte_end) begin
                                 if (is_rd)      st_nx = S_READOUT;
                                 else if (is_ad) st_nx = S_ADDR_HELD;
                                 else            st_nx = S_CMD;
                             end
                S_READOUT:   if (byte_end) st_nx = S_CMD;
                default:     st_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // shift path, bit counter, pending address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            bcnt   <= '0;
            sh     <= '0;
            osh    <= '0;
            pend   <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (!ce_s || st == S_IDLE) begin
                bcnt <= '0;
                sh   <= '0;
                osh  <= '0;
            end else if (fall) begin
                bcnt <= bcnt + 3'd1;
                sh   <= byte_w[6:0];
                if (st == S_READOUT) begin
                    osh <= {osh[6:0], 1'b0};
                end else if (byte_end && is_rd) begin
                    osh <= {4'b0000, rd_nib};
                end else if (byte_end && is_ad) begin
                    pend <= byte_w[ADR_W-1:0];
                end
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr = byte_w[ADR_W-1:0];
        wr_addr = pend;
        wr_nib  = byte_w[NIB_W-1:0];
        wr_stb  = ce_s && (st == S_ADDR_HELD) && byte_end && is_dt;
        sdo_oe  = (st == S_READOUT);
        sdo     = sdo_oe & osh[7];
    end

endmodule

// File: rtl/rtc3w_regs.sv
module rtc3w_regs
    import rtc3w_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [ADR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0] wr_nib,
    input  logic             loc_wr,
    input  logic [ADR_W-1:0] loc_addr,
    input  logic [NIB_W-1:0] loc_data,
    input  logic             loc_stop,
    input  logic [ADR_W-1:0] rd_addr,
    output logic [NIB_W-1:0] rd_nib,
    output logic             stop_flag,
    output logic             busy_flag
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [NIB_W-1:0] ent [NREG];
    logic [CW-1:0]    bsy_cnt;
    logic             t_wr;

    assign t_wr = wr_stb && is_time_addr(wr_addr);

    // self-clearing adjust timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                            bsy_cnt <= '0;
        else if (wr_stb && wr_addr == A_CTRL && wr_nib[0])     bsy_cnt <= CW'(BUSY_CYCLES);
        else if (bsy_cnt != '0)                                bsy_cnt <= bsy_cnt - 1'b1;
    end
    assign busy_flag = (bsy_cnt != '0);

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic ser_hit, loc_hit;
        assign ser_hit = wr_stb && (wr_addr == ADR_W'(i));
        assign loc_hit = loc_wr && (loc_addr == ADR_W'(i));

        if (i == int'(A_CTRL)) begin : g_ctrl
            logic [1:0] mode;
            logic       stp;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       mode <= '0;
                else if (ser_hit) mode <= wr_nib[3:2];
                else if (loc_hit) mode <= loc_data[3:2];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        stp <= 1'b1;
                else if (loc_stop) stp <= 1'b1;
                else if (t_wr)     stp <= 1'b0;
            end
            assign ent[i]    = {mode, stp, busy_flag};
            assign stop_flag = stp;
        end else if (i == int'(A_TEST)) begin : g_test
            logic tbit;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       tbit <= 1'b0;
                else if (ser_hit) tbit <= wr_nib[0];
                else if (loc_hit) tbit <= loc_data[0];
            end
            assign ent[i] = {3'b000, tbit};
        end else begin : g_plain
            logic [NIB_W-1:0] nib;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       nib <= '0;
                else if (ser_hit) nib <= wr_nib;
                else if (loc_hit) nib <= loc_data;
            end
            assign ent[i] = nib;
        end
    end

    assign rd_nib = ent[rd_addr];

endmodule

// File: rtl/rtc3w_slave.sv
module rtc3w_slave
    import rtc3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       sclk,
    input  logic       sdi,
    output logic       sdo,
    output logic       sdo_oe,
    input  logic       loc_wr,
    input  logic [3:0] loc_addr,
    input  logic [3:0] loc_data,
    input  logic       loc_stop
);

    logic             ce_s, sclk_s, bit_s;
    logic [ADR_W-1:0] rd_addr, wr_addr;
    logic [NIB_W-1:0] rd_nib, wr_nib;
    logic             wr_stb;
    logic             stop_flag, busy_flag;

    rtc3w_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce, sclk, sdi}),
        .q     ({ce_s, sclk_s, bit_s})
    );

    rtc3w_link u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .sclk_s  (sclk_s),
        .bit_s   (bit_s),
        .rd_nib  (rd_nib),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_nib  (wr_nib),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    rtc3w_regs #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_nib    (wr_nib),
        .loc_wr    (loc_wr),
        .loc_addr  (loc_addr),
        .loc_data  (loc_data),
        .loc_stop  (loc_stop),
        .rd_addr   (rd_addr),
        .rd_nib    (rd_nib),
        .stop_flag (stop_flag),
        .busy_flag (busy_flag)
    );

endmodule

// File: rtl/rtc3w_chk.sv
module rtc3w_chk
    import rtc3w_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_s,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       wr_stb,
    input logic [3:0] wr_addr,
    input logic [3:0] wr_nib,
    input logic       loc_stop,
    input logic       stop_flag,
    input logic       busy_flag
);

    // R5
    ce_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !sdo_oe);

    // R2
    resp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && is_time_addr(wr_addr) && !loc_stop) |=> !stop_flag);

    // R8
    stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_stop |=> stop_flag);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == A_CTRL && wr_nib[0]) |=> busy_flag);

    // R3
    no_write_in_readout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !sdo_oe);

endmodule

bind rtc3w_slave rtc3w_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s      (ce_s),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_nib    (wr_nib),
    .loc_stop  (loc_stop),
    .stop_flag (stop_flag),
    .busy_flag (busy_flag)
);

// File: tb/tb_rtc3w_slave.sv
module tb_rtc3w_slave;

    localparam int HALF = 8;
    localparam int BUSY = 300;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       ce = 1'b0, sclk = 1'b1, sdi = 1'b0;
    logic       loc_wr = 1'b0, loc_stop = 1'b0;
    logic [3:0] loc_addr = '0, loc_data = '0;
    logic       sdo, sdo_oe;

    rtc3w_slave #(.SYNC_STAGES(2), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .loc_data(loc_data), .loc_stop(loc_stop));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural model
    logic [3:0] m_reg [16];
    logic       m_stop, m_test;
    logic [1:0] m_mode;
    longint     m_busy_t;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // every clock: line must be released once chip enable has been low a while (R5)
    int ce_low = 0;
    always @(negedge clk) begin
        if (!ce) ce_low++; else ce_low = 0;
        if (rst_n && ce_low >= 6 && !done)
            check("R5 released while deselected", {sdo_oe, sdo}, 0);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic is_time(input logic [3:0] a);
        return (a != 4'h7) && (a < 4'hE);
    endfunction

    function automatic logic [3:0] m_exp(input logic [3:0] a);
        if (a == 4'hE) return {m_mode, m_stop, ((cyc - m_busy_t) < BUSY)};
        if (a == 4'hF) return {3'b000, m_test};
        return m_reg[a];
    endfunction

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            tick(HALF);
            sclk = 1'b0;
            tick(HALF);
            sclk = 1'b1;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic ce_on();
        ce = 1'b1;
        tick(HALF);
    endtask

    task automatic ce_off();
        tick(HALF);
        ce = 1'b0;
        tick(2 * HALF);
    endtask

    task automatic get_resp(output logic [7:0] v, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            v[i] = sdo;
            oe_all &= sdo_oe;
            sclk = 1'b0;
            tick(HALF);
            sclk = 1'b1;
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [3:0] d);
        if (a == 4'hE) begin
            m_mode = d[3:2];
            if (d[0]) m_busy_t = cyc;
        end else if (a == 4'hF) begin
            m_test = d[0];
        end else begin
            m_reg[a] = d;
        end
        if (is_time(a)) m_stop = 1'b0;
    endtask

    task automatic ser_write(input logic [3:0] a, input logic [3:0] d);
        ce_on();
        send_byte({4'b0010, a});
        send_byte({4'b0001, d});
        model_write(a, d);
        ce_off();
    endtask

    task automatic read_in_session(input logic [7:0] cmd, input string req);
        logic [7:0] v;
        logic oe_all;
        logic [3:0] e;
        send_byte(cmd);
        e = m_exp(cmd[3:0]);
        get_resp(v, oe_all);
        check(req, int'(v), int'({4'b0000, e}));
        check("R2 drive during response", int'(oe_all), 1);
        tick(2);
        check("R2 released after response", int'(sdo_oe), 0);
    endtask

    task automatic ser_read(input logic [3:0] a, input string req);
        ce_on();
        read_in_session({4'b0110, a}, req);
        ce_off();
    endtask

    task automatic loc_write(input logic [3:0] a, input logic [3:0] d);
        loc_wr = 1'b1; loc_addr = a; loc_data = d;
        tick(1);
        loc_wr = 1'b0;
        if (a == 4'hE) m_mode = d[3:2];
        else if (a == 4'hF) m_test = d[0];
        else m_reg[a] = d;
        tick(2);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_stop = 1'b1; m_test = 1'b0; m_mode = '0; m_busy_t = -100000;

        tick(5);
        // R1: reset state at the ports
        check("R1 oe after reset", int'(sdo_oe), 0);
        check("R1 sdo after reset", int'(sdo), 0);
        rst_n = 1'b1;
        tick(5);
        check("R1 oe out of reset", int'(sdo_oe), 0);
        for (int a = 0; a < 16; a++) ser_read(4'(a), "R1 reset value");

        // R3 write then read back time digits and interval
        ser_write(4'h0, 4'h9);
        ser_write(4'h1, 4'h5);
        ser_write(4'h5, 4'h2);
        ser_write(4'hC, 4'h7);
        ser_write(4'h7, 4'hA);
        ser_read(4'h0, "R3 sec units");
        ser_read(4'h1, "R3 sec tens");
        ser_read(4'h5, "R3 hour tens");
        ser_read(4'hC, "R3 year units");
        ser_read(4'h7, "R3 interval");
        ser_read(4'hE, "R8 stop cleared by time write");

        // R2 bit7 and bit4 of read byte ignored
        ce_on();
        read_in_session(8'hF0 | 8'h0C, "R2 read tag don't-care bits");
        ce_off();

        // R3 several commands in one session
        ce_on();
        send_byte(8'h24);
        send_byte(8'h13);
        model_write(4'h4, 4'h3);
        read_in_session(8'h64, "R3 write then read same session");
        ce_off();

        // R9 test register
        ser_write(4'hF, 4'hF);
        ser_read(4'hF, "R9 test bit only");
        ser_write(4'hF, 4'hE);
        ser_read(4'hF, "R9 test cleared");

        // R6 control layout, stop not writable serially
        ser_write(4'hE, 4'hE);
        ser_read(4'hE, "R6 mode bits written stop ignored");

        // R8 stop flag
        loc_stop = 1'b1; tick(1); loc_stop = 1'b0; m_stop = 1'b1; tick(2);
        ser_read(4'hE, "R8 stop set by local pulse");
        ser_write(4'h7, 4'h3);
        ser_write(4'hF, 4'h0);
        ser_read(4'hE, "R8 stop kept by non-time writes");
        ser_write(4'h9, 4'h1);
        ser_read(4'hE, "R8 stop cleared by day write");

        // R7 busy window
        ser_write(4'hE, 4'h5);
        ser_read(4'hE, "R7 busy reads set");
        tick(400);
        ser_read(4'hE, "R7 busy cleared itself");

        // R4 ignored data bytes
        ce_on();
        send_byte(8'h23);
        send_byte(8'h05);
        send_byte(8'h1A);
        send_byte(8'h1B);
        ce_off();
        ser_read(4'h3, "R4 data byte ignored");

        // R5 chip enable drop clears pending address
        ce_on();
        send_byte(8'h22);
        ce_off();
        ce_on();
        send_byte(8'h19);
        ce_off();
        ser_read(4'h2, "R5 pending address dropped");

        // R5 chip enable drop resets bit counter
        ce_on();
        send_bits(8'hFF, 4);
        ce_off();
        ser_write(4'h6, 4'h5);
        ser_read(4'h6, "R5 bit counter restarted");

        // R5 chip enable drop mid response
        ce_on();
        send_byte(8'h66);
        for (int i = 0; i < 3; i++) begin
            tick(HALF); sclk = 1'b0; tick(HALF); sclk = 1'b1;
        end
        check("R5 driving mid response", int'(sdo_oe), 1);
        ce = 1'b0;
        tick(6);
        check("R5 release on deselect", int'(sdo_oe), 0);
        tick(2 * HALF);

        // R10 local port
        loc_write(4'h9, 4'h7);
        ser_read(4'h9, "R10 local write digit");
        loc_write(4'hE, 4'hB);
        ser_read(4'hE, "R10 local control bits 3:2");
        loc_write(4'hB, 4'h1);
        ser_read(4'hE, "R10 local write leaves stop");
        ser_read(4'hB, "R10 local write month tens");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule